// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. A tester drives a test clock, a mode-select line, serial data in and an active-low test reset. The block walks the sixteen-state controller, loads one of four instructions through a 3-bit instruction path, and routes the selected data register between serial in and serial out. The data registers are a single-bit bypass cell, a 32-bit identification register and a boundary register whose length is a parameter.

The boundary register captures the chip's pin states in parallel. It also holds a set of update latches that can drive the output pins. When the external-test instruction is active, an isolation output tells the pin logic to disconnect the core and use the latched values. Serial out is given with a separate enable, so that the pad can float it outside the two shift states.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the sixteen-state test port graph, sampling TMS on the rising TCK edge. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state, and TMS high in Test-Logic-Reset keeps it there.
- R2: `trst_n` low at a rising TCK edge forces Test-Logic-Reset and makes IDCODE the active instruction. Reaching Test-Logic-Reset through TMS also makes IDCODE active.
- R3: The instruction shift stage is 3 bits wide and shifts from TDI towards TDO, least-significant bit first. In Capture-IR it loads 3'b001, so the first bit out in Shift-IR is 1, followed by 0 and 0.
- R4: The active instruction changes only on the edge that leaves Update-IR, or on reset. Shifting and pausing in the IR path leave it unchanged.
- R5: The opcodes are 3'b000 for EXTEST, 3'b010 for SAMPLE/PRELOAD, 3'b001 for IDCODE and 3'b111 for BYPASS. The values 3'b011, 3'b100, 3'b101 and 3'b110 behave as BYPASS.
- R6: Under IDCODE, Capture-DR loads the 32-bit parameter `ID_VALUE`, whose bit 0 is 1. Shift-DR presents it least-significant bit first.
- R7: Under BYPASS, a single cell captures 0 in Capture-DR. It then delays TDI by one shift, so the first bit out is 0 and bit i+1 out equals bit i in.
- R8: Under SAMPLE/PRELOAD, Capture-DR loads `pins_in`, with bit 0 first out. The edge leaving Update-DR copies the shifted-in word to `pins_out`, and `core_isolate` stays low.
- R9: Under EXTEST, `core_isolate` is high. The boundary register captures, shifts and updates `pins_out` in the same way as under SAMPLE/PRELOAD.
- R10: TDO changes only on the falling TCK edge. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR, and is low in all other states.
- R11: `pins_out` is all zeros after `trst_n`. It changes only on the edge leaving Update-DR while SAMPLE/PRELOAD or EXTEST is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising TCK |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data into the selected register |
| pins_in | input | BSR_LEN | Pin states captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO, high only in shift states |
| pins_out | output | BSR_LEN | Boundary update latches toward the output pins |
| core_isolate | output | 1 | High while EXTEST disconnects core logic from the pins |

## Verification
A wrong controller state shows at the ports within one falling edge. `tdo_oe` rises or falls in the wrong place, or the number of bits between entering and leaving a shift state no longer matches the register length, so the scanned word comes back shifted. A wrong instruction latch shows on the next data scan: a bypass-delayed word, the identification value or the pin pattern appears where a different one is expected. `core_isolate` also flips at once. A wrong update latch shows directly on `pins_out` after the next pass through Update-DR, or even without one if it moves when it should hold.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int INSN_W = 3;

  typedef enum logic [3:0] {
    TS_RESET,
    TS_IDLE,
    TS_SEL_DR,
    TS_CAP_DR,
    TS_SHF_DR,
    TS_EX1_DR,
    TS_PAU_DR,
    TS_EX2_DR,
    TS_UPD_DR,
    TS_SEL_IR,
    TS_CAP_IR,
    TS_SHF_IR,
    TS_EX1_IR,
    TS_PAU_IR,
    TS_EX2_IR,
    TS_UPD_IR
  } tap_state_e;

  localparam logic [INSN_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [INSN_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [INSN_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [INSN_W-1:0] OP_BYPASS = 3'b111;

  localparam logic [INSN_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef struct packed {
    logic extest;
    logic sample;
    logic idcode;
    logic bypass;
  } insn_sel_t;

  function automatic insn_sel_t decode_op(input logic [INSN_W-1:0] op);
    insn_sel_t s;
    s = '0;
    case (op)
      OP_EXTEST: s.extest = 1'b1;
      OP_SAMPLE: s.sample = 1'b1;
      OP_IDCODE: s.idcode = 1'b1;
      default:   s.bypass = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= nxt;
  end

  // R1
  reset_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET && tms) |=> (state == TS_RESET));

  // R1
  shift_dr_exit_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_SHF_DR && tms) |=> (state == TS_EX1_DR));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_lsb,
  output insn_sel_t  sel
);

  logic [INSN_W-1:0] shf_q;

  always_ff @(posedge tck) begin
    if (!trst_n) begin
      shf_q <= IR_CAPTURE_PAT;
    end else if (state == TS_CAP_IR) begin
      shf_q <= IR_CAPTURE_PAT;
    end else if (state == TS_SHF_IR) begin
      shf_q <= {tdi, shf_q[INSN_W-1:1]};
    end
  end

  // the decoded select is latched, so every select line is a flop output
  always_ff @(posedge tck) begin
    if (!trst_n || state == TS_RESET) sel <= decode_op(OP_IDCODE);
    else if (state == TS_UPD_IR)      sel <= decode_op(shf_q);
  end

  assign ir_lsb = shf_q[0];

  // R4
  insn_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != TS_UPD_IR && state != TS_RESET) |=> $stable(sel));

  // R5
  insn_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $countones(sel) == 1);

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_IR) |=> (shf_q == IR_CAPTURE_PAT));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A2B_3C4D
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  insn_sel_t          sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] pins_out
);

  localparam int ID_W = 32;

  logic                cap, shf, upd, bsr_en;
  logic                byp_q;
  logic [ID_W-1:0]     id_q;
  logic [BSR_LEN-1:0]  bsr_q;
  logic [BSR_LEN:0]    bsr_ext;

  assign cap    = (state == TS_CAP_DR);
  assign shf    = (state == TS_SHF_DR);
  assign upd    = (state == TS_UPD_DR);
  assign bsr_en = sel.extest | sel.sample;

  always_ff @(posedge tck) begin
    if (!trst_n)                  byp_q <= 1'b0;
    else if (cap && sel.bypass)   byp_q <= 1'b0;
    else if (shf && sel.bypass)   byp_q <= tdi;
  end

  always_ff @(posedge tck) begin
    if (!trst_n)                  id_q <= ID_VALUE;
    else if (cap && sel.idcode)   id_q <= ID_VALUE;
    else if (shf && sel.idcode)   id_q <= {tdi, id_q[ID_W-1:1]};
  end

  assign bsr_ext = {tdi, bsr_q};

  for (genvar g = 0; g < BSR_LEN; g++) begin : g_cell
    always_ff @(posedge tck) begin
      if (!trst_n)               bsr_q[g] <= 1'b0;
      else if (cap && bsr_en)    bsr_q[g] <= pins_in[g];
      else if (shf && bsr_en)    bsr_q[g] <= bsr_ext[g+1];
    end

    always_ff @(posedge tck) begin
      if (!trst_n)               pins_out[g] <= 1'b0;
      else if (upd && bsr_en)    pins_out[g] <= bsr_q[g];
    end
  end

  always_comb begin
    if (sel.idcode)   dr_lsb = id_q[0];
    else if (bsr_en)  dr_lsb = bsr_q[0];
    else              dr_lsb = byp_q;
  end

  // R11
  upd_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(upd && bsr_en) |=> $stable(pins_out));

  // R7
  bypass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (cap && sel.bypass) |=> !byp_q);

  // R6
  id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (cap && sel.idcode) |=> (id_q == ID_VALUE));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A2B_3C4D
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [BSR_LEN-1:0] pins_out,
  output logic               core_isolate
);

  tap_state_e state;
  insn_sel_t  sel;
  logic       ir_lsb, dr_lsb;

  scan_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  scan_tap_ir u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .state  (state),
    .tdi    (tdi),
    .ir_lsb (ir_lsb),
    .sel    (sel)
  );

  scan_tap_dr #(
    .BSR_LEN  (BSR_LEN),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck      (tck),
    .trst_n   (trst_n),
    .state    (state),
    .sel      (sel),
    .tdi      (tdi),
    .pins_in  (pins_in),
    .dr_lsb   (dr_lsb),
    .pins_out (pins_out)
  );

  always_ff @(negedge tck) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == TS_SHF_IR) || (state == TS_SHF_DR);
      if (state == TS_SHF_IR)      tdo <= ir_lsb;
      else if (state == TS_SHF_DR) tdo <= dr_lsb;
    end
  end

  assign core_isolate = sel.extest;

  // R10
  oe_shift_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((state == TS_SHF_IR) || (state == TS_SHF_DR)));

  // R2
  reset_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET) |=> sel.idcode);

endmodule

// File: tb/scan_tap_bench.sv
module scan_tap_bench;

  localparam int          BSR_LEN  = 8;
  localparam logic [31:0] ID_VALUE = 32'h1A2B_3C4D;

  logic               tck = 1'b0;
  logic               trst_n = 1'b0;
  logic               tms = 1'b1;
  logic               tdi = 1'b0;
  logic [BSR_LEN-1:0] pins_in = 8'hA5;
  logic               tdo, tdo_oe, core_isolate;
  logic [BSR_LEN-1:0] pins_out;

  int nchk = 0;
  int nerr = 0;
  int oe_bad = 0;

  always #10 tck = ~tck;

  scan_tap #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_scan_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pins_in(pins_in),
    .tdo(tdo), .tdo_oe(tdo_oe), .pins_out(pins_out), .core_isolate(core_isolate)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // from Run-Test/Idle, scan n bits through IR or DR, back to Run-Test/Idle
  task automatic scan(input bit ir, input int n, input logic [31:0] din,
                      output logic [31:0] dout);
    dout = '0;
    step(1'b1, 1'b0);
    if (ir) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      if (tdo_oe !== 1'b1) oe_bad++;
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_op(input logic [2:0] op);
    logic [31:0] d;
    scan(1'b1, 3, {29'd0, op}, d);
  endtask

  initial begin
    #(20 * 200000);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] dout;
    logic [7:0]  exp_upd;
    logic [7:0]  din;
    exp_upd = '0;

    repeat (3) step(1'b1, 1'b0);
    chk("R10 oe low in reset", {31'd0, tdo_oe}, 32'd0);
    chk("R11 pins_out cleared by trst_n", {24'd0, pins_out}, 32'd0);
    chk("R2 isolate low after reset", {31'd0, core_isolate}, 32'd0);
    trst_n = 1'b1;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R10 oe low in idle", {31'd0, tdo_oe}, 32'd0);

    // R2 R6: IDCODE active after reset, full 32-bit readout
    scan(1'b0, 32, 32'h0, dout);
    chk("R6 identification word", dout, ID_VALUE);

    // R3 R5 R6 R7 R8 R9 R11: sweep of every opcode
    for (int op = 0; op < 8; op++) begin
      scan(1'b1, 3, op, dout);
      chk("R3 IR capture pattern", {29'd0, dout[2:0]}, 32'd1);
      chk("R9 isolate per opcode", {31'd0, core_isolate}, {31'd0, op == 0});
      din = 8'h3C ^ 8'(op * 8'h11);
      scan(1'b0, 8, {24'd0, din}, dout);
      if (op == 0 || op == 2) begin
        chk("R8 R9 boundary capture", {24'd0, dout[7:0]}, {24'd0, pins_in});
        exp_upd = din;
      end else if (op == 1) begin
        chk("R6 IDCODE low byte", {24'd0, dout[7:0]}, {24'd0, ID_VALUE[7:0]});
      end else begin
        chk("R5 R7 bypass delay", {24'd0, dout[7:0]}, {24'd0, din[6:0], 1'b0});
      end
      chk("R11 update latches", {24'd0, pins_out}, {24'd0, exp_upd});
      pins_in = pins_in + 8'h37;
    end

    // R1: five TMS-high edges reach Test-Logic-Reset from several states
    for (int k = 0; k < 7; k++) begin
      logic [7:0] pre;
      int         len;
      case (k)
        0: begin pre = 8'b0;      len = 0; end
        1: begin pre = 8'b001;    len = 3; end
        2: begin pre = 8'b0101;   len = 4; end
        3: begin pre = 8'b11;     len = 2; end
        4: begin pre = 8'b0011;   len = 4; end
        5: begin pre = 8'b01011;  len = 5; end
        default: begin pre = 8'b1101; len = 4; end
      endcase
      load_op(3'b111);
      for (int i = 0; i < len; i++) step(pre[i], 1'b1);
      repeat (5) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      scan(1'b0, 32, 32'h0, dout);
      chk("R1 R2 five TMS-high edges reset", dout, ID_VALUE);
    end

    // R4: instruction holds during IR shift and pause
    load_op(3'b000);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    chk("R4 instruction held in Pause-IR", {31'd0, core_isolate}, 32'd1);
    chk("R10 oe low in Pause-IR", {31'd0, tdo_oe}, 32'd0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R4 instruction held in Update-IR", {31'd0, core_isolate}, 32'd1);
    step(1'b0, 1'b0);
    chk("R4 instruction taken after Update-IR", {31'd0, core_isolate}, 32'd0);

    // R10: TDO moves on the falling edge only
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R7 bypass first bit", {31'd0, tdo}, 32'd0);
    tms = 1'b0;
    tdi = 1'b1;
    @(posedge tck);
    #1;
    chk("R10 tdo stable after rising edge", {31'd0, tdo}, 32'd0);
    @(negedge tck);
    #1;
    chk("R10 tdo updated on falling edge", {31'd0, tdo}, 32'd1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R10 oe low back in idle", {31'd0, tdo_oe}, 32'd0);
    chk("R10 oe high through every shift", oe_bad, 32'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule